// File: doc/BRIEF.md
# Latched Dual Status Register Readout

This block keeps two 8-bit status registers, one for the write engine of the low bank (A) and one for the high bank (B), and presents them on a 16-bit data output while the bus is in status-read mode. The live engine signals (ready, erase-suspended, program-suspended) are followed every clock. Error events are collected into sticky bits. A separate command decoder drives the status-read mode level, the clear request and the bank-pairing mode level into the block.

A status read cycle begins when both strobes, `ce_n` and `oe_n`, are low. The block samples the strobes on the clock, so the later of the two falling edges starts the cycle. At that clock the selected status byte is copied into a snapshot, and the bus shows the snapshot until a strobe rises again. A changing engine status therefore never corrupts a value that is being read. To see newer status, the host must toggle a strobe.

In single mode the two registers act as one: error events and clears reach both registers, and a read returns a merged byte. In concurrent mode each register is separate, and `bank_sel` chooses which one a read or a clear acts on. Every change of the pairing mode wipes the error bits of both registers.

Top module: `stsr_readout`

## Requirements
- R1: The status byte carries engine ready in bit 7, erase-suspended in bit 6, the sticky errors in bits 5:3 (error input bit i of a bank lands in status bit 3+i), program-suspended in bit 2, and zeros in bits 1:0. Bank A uses `eng_*[0]` and `eng_err_set[2:0]`. Bank B uses `eng_*[1]` and `eng_err_set[5:3]`.
- R2: A read cycle starts on the first clock where both strobes are sampled low. The status byte is captured at that clock. While both strobes stay low, `dq_out` stays constant even if the engine inputs change.
- R3: Newer status becomes visible only after `ce_n` or `oe_n` has been sampled high and then both strobes are low again.
- R4: In word mode (`word_mode`=1) bits 15:8 of `dq_out` read 00h during a status read. In byte mode they read FFh (lane released).
- R5: `dq_out` is zero whenever `status_mode` is 0 or no read cycle is in progress.
- R6: While `status_mode` stays 1, each new read cycle returns status again.
- R7: Error bits stay set until a clear. If a clear and an error event reach a register in the same cycle, the event's bit ends up set.
- R8: In single mode (`conc_mode`=0) a read returns the AND of both ready bits and the OR of both registers' other bits. Error events and clears apply to both registers, whatever `clr_bank` holds.
- R9: In concurrent mode (`conc_mode`=1), `bank_sel`=0 reads bank A and 1 reads bank B. A clear acts only on the bank named by `clr_bank`, and error events go only to their own bank.
- R10: Any change of `conc_mode` clears the error bits of both registers.
- R11: After reset, all error bits are clear and `dq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conc_mode | input | 1 | 1 = concurrent (independent) registers, 0 = single (mirrored) |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| status_mode | input | 1 | Command decoder has status-read mode selected |
| bank_sel | input | 1 | Bank address for reads in concurrent mode |
| clr_req | input | 1 | Clear-status request, one clock pulse |
| clr_bank | input | 1 | Bank address for the clear in concurrent mode |
| eng_ready | input | 2 | Engine finished flag per bank |
| eng_esusp | input | 2 | Erase suspended per bank |
| eng_psusp | input | 2 | Program suspended per bank |
| eng_err_set | input | 6 | Error event pulses, 3 per bank |
| dq_out | output | 16 | Data bus output value |

## Verification
A table of read scenarios covers both pairing modes, both bank addresses and both bus widths, with different ready and suspend patterns. These scenarios tell merging apart from selection, and word-lane zeroing apart from byte-lane release. Directed sequences change the engine inputs during an open read, open a read with staggered strobe edges, and refresh a read by toggling only one strobe. Together they separate capture-at-start from transparent output. Error sequences set, clear and overlap events on each bank in each mode, then switch modes. They show stickiness, set-over-clear priority, per-bank clearing and the wipe on a mode change.

// File: rtl/stsr_pkg.sv
package stsr_pkg;

    localparam int NBANK   = 2;
    localparam int BYTE_W  = 8;
    localparam int DQ_W    = 16;
    localparam int ERR_W   = 3;
    localparam int UPPER_W = DQ_W - BYTE_W;

    typedef struct packed {
        logic             ready;
        logic             esusp;
        logic [ERR_W-1:0] err;
        logic             psusp;
        logic [1:0]       rsvd;
    } stat_t;

    // single-mode view: finished only when both engines are, anything else ORs
    function automatic stat_t merge_single(stat_t a, stat_t b);
        stat_t m;
        m.ready = a.ready & b.ready;
        m.esusp = a.esusp | b.esusp;
        m.err   = a.err | b.err;
        m.psusp = a.psusp | b.psusp;
        m.rsvd  = '0;
        return m;
    endfunction

    function automatic logic [DQ_W-1:0] format_bus(stat_t s, logic word);
        logic [UPPER_W-1:0] hi;
        hi = word ? {UPPER_W{1'b0}} : {UPPER_W{1'b1}};
        return {hi, s};
    endfunction

endpackage

// File: rtl/stsr_bank.sv
module stsr_bank
    import stsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ready,
    input  logic             esusp,
    input  logic             psusp,
    input  logic [ERR_W-1:0] err_set,
    input  logic             clr,
    input  logic             wipe,
    output stat_t            stat
);

    logic [ERR_W-1:0] err_keep;

    always_comb begin
        err_keep = (clr || wipe) ? '0 : stat.err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.ready <= ready;
            stat.esusp <= esusp;
            stat.psusp <= psusp;
            stat.err   <= err_keep | err_set;
            stat.rsvd  <= '0;
        end
    end

endmodule

// File: rtl/stsr_capture.sv
module stsr_capture
    import stsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_req,
    input  stat_t           sel_stat,
    input  logic            status_mode,
    input  logic            word_mode,
    output logic            rd_q,
    output logic [DQ_W-1:0] dq
);

    stat_t snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            snap <= '0;
        end else begin
            rd_q <= rd_req;
            if (rd_req && !rd_q) begin
                snap <= sel_stat;
            end
        end
    end

    always_comb begin
        dq = (status_mode && rd_q) ? format_bus(snap, word_mode) : '0;
    end

endmodule

// File: rtl/stsr_readout.sv
module stsr_readout
    import stsr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   conc_mode,
    input  logic                   ce_n,
    input  logic                   oe_n,
    input  logic                   word_mode,
    input  logic                   status_mode,
    input  logic                   bank_sel,
    input  logic                   clr_req,
    input  logic                   clr_bank,
    input  logic [1:0]             eng_ready,
    input  logic [1:0]             eng_esusp,
    input  logic [1:0]             eng_psusp,
    input  logic [2*ERR_W-1:0]     eng_err_set,
    output logic [DQ_W-1:0]        dq_out
);

    logic             conc_q;
    logic             mode_flip;
    logic [ERR_W-1:0] any_set;
    stat_t            bank_stat [NBANK];
    stat_t            sel_stat;
    logic             rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conc_q <= 1'b0;
        end else begin
            conc_q <= conc_mode;
        end
    end

    assign mode_flip = conc_mode ^ conc_q;

    always_comb begin
        any_set = '0;
        for (int b = 0; b < NBANK; b++) begin
            any_set = any_set | eng_err_set[b*ERR_W +: ERR_W];
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [ERR_W-1:0] set_b;
        logic             clr_b;

        assign set_b = conc_q ? eng_err_set[b*ERR_W +: ERR_W] : any_set;
        assign clr_b = clr_req && (!conc_q || (clr_bank == 1'(b)));

        stsr_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .ready   (eng_ready[b]),
            .esusp   (eng_esusp[b]),
            .psusp   (eng_psusp[b]),
            .err_set (set_b),
            .clr     (clr_b),
            .wipe    (mode_flip),
            .stat    (bank_stat[b])
        );
    end

    always_comb begin
        if (conc_q) begin
            sel_stat = bank_sel ? bank_stat[1] : bank_stat[0];
        end else begin
            sel_stat = merge_single(bank_stat[0], bank_stat[1]);
        end
    end

    stsr_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (!ce_n && !oe_n),
        .sel_stat    (sel_stat),
        .status_mode (status_mode),
        .word_mode   (word_mode),
        .rd_q        (rd_q),
        .dq          (dq_out)
    );

endmodule

// File: rtl/stsr_readout_chk.sv
module stsr_readout_chk
    import stsr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               conc_mode,
    input logic               conc_q,
    input logic               status_mode,
    input logic               word_mode,
    input logic               rd_q,
    input logic [2*ERR_W-1:0] eng_err_set,
    input stat_t              stat_a,
    input stat_t              stat_b,
    input logic [DQ_W-1:0]    dq_out
);

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_q && $past(rd_q) && status_mode && $stable(status_mode) && $stable(word_mode))
        |-> $stable(dq_out));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (status_mode && word_mode) |-> (dq_out[DQ_W-1:BYTE_W] == '0));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_q || !status_mode) |-> (dq_out == '0));

    assert_single_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        !conc_q |-> (stat_a.err == stat_b.err));

    assert_mode_wipe_R10: assert property (@(posedge clk) disable iff (rst)
        ((conc_mode != conc_q) && (eng_err_set == '0))
        |=> ((stat_a.err == '0) && (stat_b.err == '0)));

    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((dq_out == '0) && (stat_a.err == '0) && (stat_b.err == '0)));

endmodule

bind stsr_readout stsr_readout_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .conc_mode   (conc_mode),
    .conc_q      (conc_q),
    .status_mode (status_mode),
    .word_mode   (word_mode),
    .rd_q        (rd_q),
    .eng_err_set (eng_err_set),
    .stat_a      (bank_stat[0]),
    .stat_b      (bank_stat[1]),
    .dq_out      (dq_out)
);

// File: tb/stsr_readout_bench.sv
`timescale 1ns/1ps
module stsr_readout_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conc_mode = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        word_mode = 1'b1;
    logic        status_mode = 1'b0;
    logic        bank_sel = 1'b0;
    logic        clr_req = 1'b0;
    logic        clr_bank = 1'b0;
    logic [1:0]  eng_ready = 2'b00;
    logic [1:0]  eng_esusp = 2'b00;
    logic [1:0]  eng_psusp = 2'b00;
    logic [5:0]  eng_err_set = 6'b0;
    logic [15:0] dq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    stsr_readout u_stsr_readout (
        .clk(clk), .rst(rst), .conc_mode(conc_mode), .ce_n(ce_n), .oe_n(oe_n),
        .word_mode(word_mode), .status_mode(status_mode), .bank_sel(bank_sel),
        .clr_req(clr_req), .clr_bank(clr_bank), .eng_ready(eng_ready),
        .eng_esusp(eng_esusp), .eng_psusp(eng_psusp), .eng_err_set(eng_err_set),
        .dq_out(dq_out)
    );

    // {conc, sel, word, ready[1:0], esusp[1:0], psusp[1:0], expected[15:0]}
    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 2'b00, 16'h0080},
        {1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 2'b00, 16'h0000},
        {1'b0, 1'b0, 1'b1, 2'b11, 2'b10, 2'b00, 16'h00C0},
        {1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 2'b01, 16'hFF84},
        {1'b1, 1'b0, 1'b1, 2'b01, 2'b00, 2'b00, 16'h0080},
        {1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 2'b00, 16'h0000},
        {1'b1, 1'b1, 1'b1, 2'b10, 2'b10, 2'b10, 16'h00C4},
        {1'b1, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00, 16'hFF40}
    };

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dq_out=%h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [15:0] val);
        ce_n = 1'b0;
        oe_n = 1'b0;
        tick();
        val = dq_out;
        ce_n = 1'b1;
        oe_n = 1'b1;
        tick();
    endtask

    task automatic pulse_err(logic [5:0] e);
        eng_err_set = e;
        tick();
        eng_err_set = '0;
        tick(2);
    endtask

    task automatic pulse_clr(logic bank);
        clr_bank = bank;
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        tick(2);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        tick(3);
        rst = 1'b0;
        tick();
        check("R11 reset output", dq_out, 16'h0000);
        status_mode = 1'b1;
        do_read(rv);
        check("R11 reset status all clear", rv, 16'h0000);

        // table walk: R1 R4 R8 R9
        for (int v = 0; v < NV; v++) begin
            conc_mode   = VEC[v][24];
            bank_sel    = VEC[v][23];
            word_mode   = VEC[v][22];
            eng_ready   = VEC[v][21:20];
            eng_esusp   = VEC[v][19:18];
            eng_psusp   = VEC[v][17:16];
            tick(3);
            do_read(rv);
            check($sformatf("R1/R4/R8/R9 vector %0d", v), rv, VEC[v][15:0]);
        end

        // R5: idle and non-status reads
        word_mode = 1'b1; conc_mode = 1'b1; bank_sel = 1'b0;
        eng_ready = 2'b11; eng_esusp = 2'b00; eng_psusp = 2'b00;
        tick(3);
        check("R5 no strobe", dq_out, 16'h0000);
        status_mode = 1'b0;
        do_read(rv);
        check("R5 status mode off", rv, 16'h0000);
        status_mode = 1'b1;

        // R6: consecutive reads keep returning status
        do_read(rv);
        check("R6 first read", rv, 16'h0080);
        do_read(rv);
        check("R6 second read", rv, 16'h0080);

        // R2: hold during open read
        ce_n = 1'b0; oe_n = 1'b0;
        tick();
        check("R2 captured", dq_out, 16'h0080);
        eng_ready = 2'b00;
        tick(3);
        check("R2 held while live changes", dq_out, 16'h0080);
        // R3: toggle ce_n only
        ce_n = 1'b1;
        tick();
        ce_n = 1'b0;
        tick();
        check("R3 refresh after ce toggle", dq_out, 16'h0000);
        ce_n = 1'b1; oe_n = 1'b1;
        tick();

        // R2: later falling edge starts the cycle
        ce_n = 1'b0;
        tick();
        eng_ready = 2'b11;
        tick(2);
        oe_n = 1'b0;
        tick();
        check("R2 capture at later strobe", dq_out, 16'h0080);
        ce_n = 1'b1; oe_n = 1'b1;
        tick();

        // R7 / R9: concurrent sticky errors
        pulse_err(6'b000_001);
        bank_sel = 1'b0; do_read(rv);
        check("R7 bank A error sticky", rv, 16'h0088);
        bank_sel = 1'b1; do_read(rv);
        check("R9 bank B untouched", rv, 16'h0080);
        pulse_clr(1'b1);
        bank_sel = 1'b0; do_read(rv);
        check("R9 clear of B leaves A", rv, 16'h0088);
        // R7: set wins over simultaneous clear
        clr_bank = 1'b0; clr_req = 1'b1; eng_err_set = 6'b000_010;
        tick();
        clr_req = 1'b0; eng_err_set = '0;
        tick(2);
        do_read(rv);
        check("R7 set beats clear", rv, 16'h0090);
        pulse_clr(1'b0);
        do_read(rv);
        check("R7 clear A", rv, 16'h0080);

        // R10: leaving concurrent mode wipes; then R8 single-mode errors
        pulse_err(6'b100_000);
        conc_mode = 1'b0;
        tick(3);
        do_read(rv);
        check("R10 wipe on entering single", rv, 16'h0080);
        pulse_err(6'b100_000);
        bank_sel = 1'b0; do_read(rv);
        check("R8 single merged error sel0", rv, 16'h00A0);
        bank_sel = 1'b1; do_read(rv);
        check("R8 single merged error sel1", rv, 16'h00A0);
        pulse_clr(1'b1);
        do_read(rv);
        check("R8 single clear hits both", rv, 16'h0080);

        // R10: entering concurrent mode wipes both
        pulse_err(6'b000_001);
        do_read(rv);
        check("R8 single error from A", rv, 16'h0088);
        conc_mode = 1'b1;
        tick(3);
        bank_sel = 1'b0; do_read(rv);
        check("R10 bank A wiped", rv, 16'h0080);
        bank_sel = 1'b1; do_read(rv);
        check("R10 bank B wiped", rv, 16'h0080);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule